// File: doc/BRIEF.md
# Microcoded Memory Strobe Sequencer

This block produces the external memory strobes for one bus request by running a short program of control words. The words are held in a small writable store. Each word sets the general-purpose output lines for the two halves of a bus-clock cycle and the byte-select strobes. Three control fields in the word steer the program: a LAST flag that ends it, a LOOP flag that marks counted loops, and a 2-bit REDO count that repeats the current word.

A request names one of six kinds: single-beat read, burst read, single-beat write, burst write, refresh-timer expiry, or a software-started run. The kind picks the first word of the program and which loop-count field is used. A bus-monitor exception stops any program at once and clears every strobe. Words are loaded through a plain write port. Address generation, arbitration and the refresh timer are outside this block.

Top module: `ucode_mseq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o`, `gp_rise_o`, `gp_fall_o` and `bs_o` are all 0.
- R2: In idle, a request with `req_type_i` 0..4 (0 single read, 1 burst read, 2 single write, 3 burst write, 4 refresh) starts at word `req_type_i * 2**AW/8`, and kind 5 starts at `run_start_i`. Kinds 6 and 7 are ignored and leave `busy_o` at 0.
- R3: Control word bit layout: [19] LAST, [18] LOOP, [17:16] REDO, [15:12] byte strobes, [11:6] rising-phase lines, [5:0] falling-phase lines. A word executed at one clock edge drives these fields onto `bs_o`, `gp_rise_o` and `gp_fall_o` for the cycle after that edge. The first word's values appear in the second cycle after the request is sampled.
- R4: When a LAST word finishes its final repetition, `done_o` is 1 for exactly that output cycle and `busy_o` is already 0. All outputs are 0 in the cycle after.
- R5: A word with REDO = k appears on the outputs for k+1 consecutive cycles before the program moves on.
- R6: The first LOOP word opens a loop and the next LOOP word closes it. The words from the opening word to the closing word run N times. N is `rd_loops_i` for kinds 0, 1 and 5, `wr_loops_i` for kinds 2 and 3, and `tmr_loops_i` for kind 4, sampled when the request is accepted. A value of 0 means 2**LOOP_W. After the last pass, execution continues after the closing word.
- R7: Loops placed one after another in the same program each run their own full count.
- R8: A word with both LAST and LOOP set gives a one-cycle `err_o` with all strobe outputs 0 in place of that word, and returns to idle without `done_o`.
- R9: A LAST word reached while a loop is open is handled the same way as R8.
- R10: When `g0_follow_i` is 1 and a word sets line 0 in both phases, line 0 carries `addr_i[g0_sel_i]` in both phases. The other lines are unaffected.
- R11: An `exc_i` pulse sampled at an edge makes all strobe outputs, `busy_o` and `done_o` 0 in the following cycle. No further word of that program runs, and a later request runs normally.
- R12: A request arriving while `busy_o` is 1 is dropped and does not change the running program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| req_type_i | input | 3 | Request kind (see R2) |
| run_start_i | input | AW | First word for a software run |
| rd_loops_i | input | LOOP_W | Loop count for read and run requests |
| wr_loops_i | input | LOOP_W | Loop count for write requests |
| tmr_loops_i | input | LOOP_W | Loop count for refresh requests |
| g0_follow_i | input | 1 | Allow line 0 to follow an address bit |
| g0_sel_i | input | $clog2(ADDR_IN_W) | Which address bit line 0 follows |
| addr_i | input | ADDR_IN_W | Current bus address |
| exc_i | input | 1 | Bus-monitor exception |
| ram_we_i | input | 1 | Control store write enable |
| ram_waddr_i | input | AW | Control store write address |
| ram_wdata_i | input | 20 | Control word to store |
| gp_rise_o | output | 6 | Line values for the high half of the cycle |
| gp_fall_o | output | 6 | Line values for the low half of the cycle |
| bs_o | output | 4 | Byte-select strobes, 1 = active |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle program-fault pulse |

## Verification
The bench uses the default parameters: AW = 6, which gives 64 words and 8-word regions, LOOP_W = 4 and ADDR_IN_W = 8. With a 4-bit count, the zero-means-sixteen case and full REDO chains inside long loops finish in a few hundred cycles. So the wrap case is tested directly, next to short random programs in every request region and in the run region at word 48. The 3-bit address-select field lets line 0 be tied to a high address bit and toggled.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
    localparam int GP_N = 6;
    localparam int BS_N = 4;

    typedef struct packed {
        logic            last;
        logic            loop;
        logic [1:0]      redo;
        logic [BS_N-1:0] bs;
        logic [GP_N-1:0] rise;
        logic [GP_N-1:0] fall;
    } ctl_word_t;

    localparam int WORD_W = $bits(ctl_word_t);

    typedef enum logic [2:0] {
        REQ_RD_SB   = 3'd0,
        REQ_RD_BU   = 3'd1,
        REQ_WR_SB   = 3'd2,
        REQ_WR_BU   = 3'd3,
        REQ_REFRESH = 3'd4,
        REQ_RUN     = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        LSRC_READ  = 2'd0,
        LSRC_WRITE = 2'd1,
        LSRC_TIMER = 2'd2
    } loop_src_e;

    function automatic loop_src_e loop_src(input logic [2:0] kind);
        case (kind)
            3'(REQ_WR_SB), 3'(REQ_WR_BU): return LSRC_WRITE;
            3'(REQ_REFRESH):              return LSRC_TIMER;
            default:                      return LSRC_READ;
        endcase
    endfunction
endpackage

// File: rtl/mseq_ram.sv
`timescale 1ns/1ps
module mseq_ram #(
    parameter int AW    = 6,
    parameter int DW    = 20,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store[waddr_i] <= wdata_i;
    end

    assign rdata_o = store[raddr_i];
endmodule

// File: rtl/mseq_seq.sv
`timescale 1ns/1ps
module mseq_seq
    import mseq_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LOOP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [2:0]        req_type_i,
    input  logic [AW-1:0]     run_start_i,
    input  logic [LOOP_W-1:0] rd_loops_i,
    input  logic [LOOP_W-1:0] wr_loops_i,
    input  logic [LOOP_W-1:0] tmr_loops_i,
    input  logic              exc_i,
    input  logic              w_last_i,
    input  logic              w_loop_i,
    input  logic [1:0]        w_redo_i,
    output logic [AW-1:0]     pc_o,
    output logic              busy_o,
    output logic              emit_o,
    output logic              bad_o,
    output logic              fin_o
);
    logic              busy_q, in_loop_q;
    logic [AW-1:0]     pc_q, ls_q, start_pc;
    logic [LOOP_W-1:0] cnt_q, lim_q, lim_sel;
    logic [1:0]        rep_q;
    logic              accept, last_rep;

    assign accept   = !busy_q && req_i && !exc_i && (req_type_i <= 3'(REQ_RUN));
    assign last_rep = (rep_q == w_redo_i);
    assign bad_o    = busy_q && !exc_i && w_last_i && (w_loop_i || in_loop_q);
    assign emit_o   = busy_q && !exc_i && !bad_o;
    assign fin_o    = emit_o && last_rep && w_last_i;
    assign pc_o     = pc_q;
    assign busy_o   = busy_q;

    always_comb begin
        if (req_type_i == 3'(REQ_RUN)) start_pc = run_start_i;
        else                           start_pc = {req_type_i, {(AW-3){1'b0}}};
        case (loop_src(req_type_i))
            LSRC_WRITE: lim_sel = wr_loops_i;
            LSRC_TIMER: lim_sel = tmr_loops_i;
            default:    lim_sel = rd_loops_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            in_loop_q <= 1'b0;
            pc_q      <= '0;
            ls_q      <= '0;
            cnt_q     <= '0;
            lim_q     <= '0;
            rep_q     <= '0;
        end else if (exc_i) begin
            busy_q    <= 1'b0;
            in_loop_q <= 1'b0;
            rep_q     <= '0;
        end else if (!busy_q) begin
            if (accept) begin
                busy_q    <= 1'b1;
                pc_q      <= start_pc;
                lim_q     <= lim_sel;
                in_loop_q <= 1'b0;
                rep_q     <= '0;
            end
        end else if (bad_o) begin
            busy_q    <= 1'b0;
            in_loop_q <= 1'b0;
            rep_q     <= '0;
        end else if (!last_rep) begin
            rep_q <= rep_q + 2'd1;
        end else begin
            rep_q <= '0;
            if (w_last_i) begin
                busy_q <= 1'b0;
            end else if (w_loop_i && !in_loop_q) begin
                in_loop_q <= 1'b1;
                ls_q      <= pc_q;
                cnt_q     <= lim_q;
                pc_q      <= pc_q + 1'b1;
            end else if (w_loop_i && (pc_q == ls_q)) begin
                pc_q <= pc_q + 1'b1;
            end else if (w_loop_i) begin
                if (cnt_q != LOOP_W'(1)) begin
                    cnt_q <= cnt_q - 1'b1;
                    pc_q  <= ls_q;
                end else begin
                    in_loop_q <= 1'b0;
                    pc_q      <= pc_q + 1'b1;
                end
            end else begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mseq_drv.sv
`timescale 1ns/1ps
module mseq_drv
    import mseq_pkg::*;
#(
    parameter int ADDR_IN_W = 8,
    localparam int SEL_W    = $clog2(ADDR_IN_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 emit_i,
    input  logic                 bad_i,
    input  logic                 fin_i,
    input  logic [GP_N-1:0]      rise_i,
    input  logic [GP_N-1:0]      fall_i,
    input  logic [BS_N-1:0]      bs_i,
    input  logic                 g0_follow_i,
    input  logic [SEL_W-1:0]     g0_sel_i,
    input  logic [ADDR_IN_W-1:0] addr_i,
    output logic [GP_N-1:0]      gp_rise_o,
    output logic [GP_N-1:0]      gp_fall_o,
    output logic [BS_N-1:0]      bs_o,
    output logic                 done_o,
    output logic                 err_o
);
    logic            follow, abit;
    logic [GP_N-1:0] rise_n, fall_n;

    assign follow = g0_follow_i && rise_i[0] && fall_i[0];
    assign abit   = addr_i[g0_sel_i];

    always_comb begin
        rise_n = rise_i;
        fall_n = fall_i;
        if (follow) begin
            rise_n[0] = abit;
            fall_n[0] = abit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !emit_i) begin
            gp_rise_o <= '0;
            gp_fall_o <= '0;
            bs_o      <= '0;
        end else begin
            gp_rise_o <= rise_n;
            gp_fall_o <= fall_n;
            bs_o      <= bs_i;
        end
        done_o <= !rst && fin_i;
        err_o  <= !rst && bad_i;
    end
endmodule

// File: rtl/ucode_mseq.sv
`timescale 1ns/1ps
module ucode_mseq
    import mseq_pkg::*;
#(
    parameter int AW        = 6,
    parameter int LOOP_W    = 4,
    parameter int ADDR_IN_W = 8,
    localparam int SEL_W    = $clog2(ADDR_IN_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [2:0]           req_type_i,
    input  logic [AW-1:0]        run_start_i,
    input  logic [LOOP_W-1:0]    rd_loops_i,
    input  logic [LOOP_W-1:0]    wr_loops_i,
    input  logic [LOOP_W-1:0]    tmr_loops_i,
    input  logic                 g0_follow_i,
    input  logic [SEL_W-1:0]     g0_sel_i,
    input  logic [ADDR_IN_W-1:0] addr_i,
    input  logic                 exc_i,
    input  logic                 ram_we_i,
    input  logic [AW-1:0]        ram_waddr_i,
    input  logic [WORD_W-1:0]    ram_wdata_i,
    output logic [GP_N-1:0]      gp_rise_o,
    output logic [GP_N-1:0]      gp_fall_o,
    output logic [BS_N-1:0]      bs_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);
    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] rd_raw;
    ctl_word_t         word;
    logic              emit, bad, fin;

    assign word = ctl_word_t'(rd_raw);

    mseq_ram #(.AW(AW), .DW(WORD_W)) u_ram (
        .clk(clk), .we_i(ram_we_i), .waddr_i(ram_waddr_i), .wdata_i(ram_wdata_i),
        .raddr_i(pc), .rdata_o(rd_raw)
    );

    mseq_seq #(.AW(AW), .LOOP_W(LOOP_W)) u_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .req_type_i(req_type_i),
        .run_start_i(run_start_i), .rd_loops_i(rd_loops_i), .wr_loops_i(wr_loops_i),
        .tmr_loops_i(tmr_loops_i), .exc_i(exc_i), .w_last_i(word.last),
        .w_loop_i(word.loop), .w_redo_i(word.redo), .pc_o(pc), .busy_o(busy_o),
        .emit_o(emit), .bad_o(bad), .fin_o(fin)
    );

    mseq_drv #(.ADDR_IN_W(ADDR_IN_W)) u_drv (
        .clk(clk), .rst(rst), .emit_i(emit), .bad_i(bad), .fin_i(fin),
        .rise_i(word.rise), .fall_i(word.fall), .bs_i(word.bs),
        .g0_follow_i(g0_follow_i), .g0_sel_i(g0_sel_i), .addr_i(addr_i),
        .gp_rise_o(gp_rise_o), .gp_fall_o(gp_fall_o), .bs_o(bs_o),
        .done_o(done_o), .err_o(err_o)
    );
endmodule

// File: rtl/ucode_mseq_chk.sv
`timescale 1ns/1ps
module ucode_mseq_chk
    import mseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_i,
    input logic [2:0]      req_type_i,
    input logic            exc_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [BS_N-1:0] bs_o,
    input logic [GP_N-1:0] gp_rise_o,
    input logic [GP_N-1:0] gp_fall_o
);
    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i && !exc_i && req_type_i <= 3'd5) |=> busy_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!done_o && bs_o == '0 && gp_rise_o == '0 && gp_fall_o == '0));

    // R11
    exc_clears_chk: assert property (@(posedge clk) disable iff (rst)
        exc_i |=> (bs_o == '0 && !busy_o && !done_o && gp_rise_o == '0));
endmodule

bind ucode_mseq ucode_mseq_chk u_chk (.*);

// File: tb/tb_ucode_mseq.sv
`timescale 1ns/1ps
module tb_ucode_mseq;
    import mseq_pkg::*;

    localparam int AW = 6, LOOP_W = 4, AIW = 8, SEL_W = 3, MAXT = 1024;

    logic clk = 1'b0, rst = 1'b1;
    logic req_i = 1'b0, g0_follow_i = 1'b0, exc_i = 1'b0, ram_we_i = 1'b0;
    logic [2:0] req_type_i = '0;
    logic [AW-1:0] run_start_i = 6'd48, ram_waddr_i = '0;
    logic [LOOP_W-1:0] rd_loops_i = 4'd1, wr_loops_i = 4'd1, tmr_loops_i = 4'd1;
    logic [SEL_W-1:0] g0_sel_i = '0;
    logic [AIW-1:0] addr_i = '0;
    logic [WORD_W-1:0] ram_wdata_i = '0;
    logic [GP_N-1:0] gp_rise_o, gp_fall_o;
    logic [BS_N-1:0] bs_o;
    logic busy_o, done_o, err_o;

    always #2.5 clk = ~clk;

    ucode_mseq dut (.*);

    ctl_word_t img [64];
    logic [GP_N-1:0] er [MAXT];
    logic [GP_N-1:0] ef [MAXT];
    logic [BS_N-1:0] eb [MAXT];
    logic ed [MAXT];
    logic ee [MAXT];
    int ne;
    int checks = 0, fails = 0;

    function automatic ctl_word_t mk(input logic l, input logic lp, input logic [1:0] rd,
                                     input logic [3:0] b, input logic [5:0] r, input logic [5:0] f);
        ctl_word_t w;
        w.last = l; w.loop = lp; w.redo = rd; w.bs = b; w.rise = r; w.fall = f;
        return w;
    endfunction

    task automatic load(input int a, input ctl_word_t w);
        img[a] = w;
        @(negedge clk);
        ram_we_i = 1'b1; ram_waddr_i = AW'(a); ram_wdata_i = w;
        @(negedge clk);
        ram_we_i = 1'b0;
    endtask

    task automatic push(input ctl_word_t w, input logic d, input logic e);
        logic [5:0] r, f;
        r = w.rise; f = w.fall;
        if (g0_follow_i && r[0] && f[0]) begin
            r[0] = addr_i[g0_sel_i];
            f[0] = addr_i[g0_sel_i];
        end
        if (e) begin r = '0; f = '0; end
        er[ne] = r; ef[ne] = f; eb[ne] = e ? 4'h0 : w.bs; ed[ne] = d; ee[ne] = e;
        ne++;
    endtask

    // expected output trace from the requirements (R2..R9)
    task automatic build(input logic [2:0] kind);
        int pc, ls, iter, lim, steps;
        logic inl;
        ctl_word_t w;
        logic [3:0] fld;
        ne = 0; inl = 0; ls = 0; iter = 0; lim = 1; steps = 0;
        pc = (kind == 3'd5) ? int'(run_start_i) : int'(kind) * 8;
        fld = (kind == 3'd2 || kind == 3'd3) ? wr_loops_i : (kind == 3'd4) ? tmr_loops_i : rd_loops_i;
        while (steps < 400 && ne < MAXT - 8) begin
            steps++;
            w = img[pc];
            if (w.last && (w.loop || inl)) begin
                push(w, 1'b0, 1'b1);
                return;
            end
            for (int r = 0; r <= int'(w.redo); r++)
                push(w, (r == int'(w.redo)) && w.last, 1'b0);
            if (w.last) return;
            if (w.loop && !inl) begin
                inl = 1; ls = pc; iter = 0; lim = (fld == 0) ? 16 : int'(fld);
                pc = (pc + 1) % 64;
            end else if (w.loop && pc == ls) begin
                pc = (pc + 1) % 64;
            end else if (w.loop) begin
                iter++;
                if (iter < lim) pc = ls;
                else begin inl = 0; pc = (pc + 1) % 64; end
            end else pc = (pc + 1) % 64;
        end
    endtask

    task automatic chk_idle(input string tag);
        checks++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || err_o !== 1'b0 ||
            gp_rise_o !== '0 || gp_fall_o !== '0 || bs_o !== '0) begin
            fails++;
            $display("FAIL %s idle: got busy=%b done=%b err=%b rise=%h fall=%h bs=%h, expected all 0",
                     tag, busy_o, done_o, err_o, gp_rise_o, gp_fall_o, bs_o);
        end
    endtask

    task automatic run_check(input logic [2:0] kind, input string tag, input int exc_at, input int poke_at);
        build(kind);
        @(negedge clk);
        req_i = 1'b1; req_type_i = kind;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        for (int i = 0; i < ne; i++) begin
            checks++;
            if ({gp_rise_o, gp_fall_o, bs_o, done_o, err_o, busy_o} !==
                {er[i], ef[i], eb[i], ed[i], ee[i], !(ed[i] || ee[i])}) begin
                fails++;
                $display("FAIL %s cycle %0d: got rise=%h fall=%h bs=%h done=%b err=%b busy=%b, expected rise=%h fall=%h bs=%h done=%b err=%b busy=%b",
                         tag, i, gp_rise_o, gp_fall_o, bs_o, done_o, err_o, busy_o,
                         er[i], ef[i], eb[i], ed[i], ee[i], !(ed[i] || ee[i]));
            end
            if (i == poke_at) begin req_i = 1'b1; req_type_i = 3'd0; end
            if (i == exc_at) exc_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            if (exc_i) begin exc_i = 1'b0; break; end
        end
        chk_idle(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset");

        // R3 basic output mapping, R2 region of kind 0, R4 done
        load(0, mk(0, 0, 0, 4'h3, 6'h2A, 6'h15));
        load(1, mk(0, 0, 0, 4'hC, 6'h01, 6'h3E));
        load(2, mk(1, 0, 0, 4'hF, 6'h3F, 6'h00));
        run_check(3'd0, "R3 plain words", -1, -1);

        // R5 redo, with R12 request while busy
        load(8, mk(0, 0, 3, 4'h5, 6'h11, 6'h22));
        load(9, mk(1, 0, 1, 4'hA, 6'h07, 6'h38));
        run_check(3'd1, "R5 redo", -1, -1);
        run_check(3'd1, "R12 busy request dropped", -1, 1);

        // R6 counted loop with write count
        load(16, mk(0, 1, 0, 4'h1, 6'h01, 6'h00));
        load(17, mk(0, 0, 1, 4'h2, 6'h02, 6'h00));
        load(18, mk(0, 1, 0, 4'h4, 6'h04, 6'h00));
        load(19, mk(1, 0, 0, 4'h8, 6'h08, 6'h00));
        wr_loops_i = 4'd3;
        run_check(3'd2, "R6 loop count 3", -1, -1);
        wr_loops_i = 4'd0;
        run_check(3'd3 - 3'd1, "R6 loop count 0 wraps to 16", -1, -1);

        // R11 exception mid-run then recovery
        wr_loops_i = 4'd3;
        run_check(3'd2, "R11 exception abort", 2, -1);
        run_check(3'd2, "R11 recovery run", -1, -1);

        // R7 back-to-back loops on the refresh count
        load(32, mk(0, 1, 0, 4'h1, 6'h10, 6'h01));
        load(33, mk(0, 1, 0, 4'h2, 6'h20, 6'h02));
        load(34, mk(0, 1, 1, 4'h3, 6'h30, 6'h03));
        load(35, mk(0, 1, 0, 4'h4, 6'h08, 6'h04));
        load(36, mk(1, 0, 0, 4'h5, 6'h04, 6'h05));
        tmr_loops_i = 4'd2;
        run_check(3'd4, "R7 sequential loops", -1, -1);

        // R8 LAST with LOOP
        load(24, mk(0, 0, 0, 4'h6, 6'h06, 6'h06));
        load(25, mk(1, 1, 0, 4'hF, 6'h3F, 6'h3F));
        run_check(3'd3, "R8 last+loop fault", -1, -1);

        // R9 LAST inside open loop, run kind uses read count (R6)
        run_start_i = 6'd48;
        load(48, mk(0, 1, 0, 4'h9, 6'h09, 6'h09));
        load(49, mk(1, 0, 0, 4'hF, 6'h3F, 6'h3F));
        rd_loops_i = 4'd2;
        run_check(3'd5, "R9 last in open loop", -1, -1);

        // R10 line 0 follows an address bit
        load(0, mk(0, 0, 0, 4'h1, 6'h21, 6'h03));
        load(1, mk(1, 0, 0, 4'h2, 6'h01, 6'h00));
        g0_follow_i = 1'b1; g0_sel_i = 3'd5; addr_i = 8'h20;
        run_check(3'd0, "R10 follow high", -1, -1);
        addr_i = 8'hDF;
        run_check(3'd0, "R10 follow low", -1, -1);
        g0_follow_i = 1'b0;

        // R2 unused kinds are ignored
        @(negedge clk);
        req_i = 1'b1; req_type_i = 3'd6;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        chk_idle("R2 kind 6 ignored");

        // random programs across all kinds (R2..R7)
        for (int it = 0; it < 40; it++) begin
            logic [2:0] kind;
            int base, len, a, b;
            logic hasl;
            kind = 3'($urandom % 6);
            base = (kind == 3'd5) ? 48 : int'(kind) * 8;
            len = 2 + int'($urandom % 6);
            hasl = (len >= 3) && ($urandom % 2 == 0);
            a = 0; b = 0;
            if (hasl) begin
                a = int'($urandom % (len - 2));
                b = a + 1 + int'($urandom % (len - 2 - a));
            end
            for (int j = 0; j < len; j++)
                load(base + j, mk(j == len - 1, hasl && (j == a || j == b), 2'($urandom),
                                  4'($urandom), 6'($urandom), 6'($urandom)));
            rd_loops_i = 4'($urandom % 4);
            wr_loops_i = 4'($urandom % 4);
            tmr_loops_i = 4'($urandom % 4);
            run_check(kind, "R6 random program", -1, -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule